// File: doc/BRIEF.md
# Lock-Aware Output Mode Selector

This block is the routing and per-output content logic of a two-output serial retimer with two candidate inputs. A two-bit route field picks the active input and which outputs are powered. A small link state machine follows the signal-detect flag of the active input and the recovery-loop lock flag. From that state, a global mode field, and an optional override with separate per-output codes, it decides what each output carries. The choices are silence, raw input data, retimed data, a full-rate recovered clock, a 297 MHz clock, a 10 MHz reference clock or a divided clock.

All data and clock sources enter as single-bit streams and pass through combinational gating to the two outputs. Only the link state is registered, so a change in lock or signal detect reaches the outputs one clock later. Configuration fields reach them at once. The link state machine has three states. LINK_DARK means no signal on the active input. LINK_ACQUIRE means a signal is present but the loop is not locked. LINK_LOCKED means a signal is present and the loop is locked. The transition to LINK_DARK is taken whenever signal detect is low. The transition to LINK_ACQUIRE is taken when signal detect is high and lock is low. The transition to LINK_LOCKED is taken when both are high. Each transition can be taken from any state, and reset enters LINK_DARK.

Top module: `lock_aware_out_sel`

## Requirements
- R1: Route field `route_sel` picks the active input and the powered outputs. 2'b00 sends input 0 to both outputs. 2'b01 sends input 0 to output 0 and sets `out1_pd`. 2'b10 sends input 1 to output 1 and sets `out0_pd`. 2'b11 sends input 1 to both outputs. A powered-down output drives 0.
- R2: The link state is registered and updates one clock after `cdr_lock` or the active input's signal detect changes. After reset, and in LINK_DARK, both power-down flags are 1 and both outputs drive 0.
- R3: With `ovr_en`=0 and `glob_mode`=2'b00, both outputs drive 0.
- R4: With `ovr_en`=0 and `glob_mode`=2'b01, output 0 carries retimed data when locked and raw data when not locked. Output 1 carries a clock when locked and 0 when not locked. That clock is the full-rate clock when `rate_high`=0 and the 297 MHz clock when `rate_high`=1.
- R5: With `ovr_en`=0, `glob_mode`=2'b10 gives retimed data on both outputs when locked and raw data when not locked. `glob_mode`=2'b11 gives raw data on both outputs in every link state that has a signal.
- R6: With `ovr_en`=1, `out0_code` selects output 0 content. 3'b000 is mute, 3'b001 is the 10 MHz clock, 3'b010 is raw data and 3'b100 is retimed data.
- R7: With `ovr_en`=1, `out1_code` selects output 1 content. 3'b111 is mute, 3'b000 is raw data, 3'b001 is retimed data and 3'b010 is the full-rate clock. 3'b101 gives the 10 MHz clock when `div_sel`=0 and the divided clock when `div_sel`=1.
- R8: The 10 MHz clock appears only while signal detect is active, and lock is not needed. Output 0 carries it only when `out1_code`=3'b101 and `div_sel`=0.
- R9: Retimed data selected by an override code while not locked makes that output drive 0.
- R10: `out1_inv`=1 inverts output 1 whenever it carries content. A muted or powered-down output 1 still drives 0.
- R11: Override codes not listed in R6 and R7 mute their output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| route_sel | input | 2 | Input/output route field |
| glob_mode | input | 2 | Global output mode field |
| ovr_en | input | 1 | Selects the per-output override codes |
| out0_code | input | 3 | Output 0 override code |
| out1_code | input | 3 | Output 1 override code |
| div_sel | input | 1 | Code 101 on output 1: 0 = 10 MHz, 1 = divided clock |
| out1_inv | input | 1 | Inverts output 1 polarity |
| rate_high | input | 1 | Line rate above 3 Gbps |
| cdr_lock | input | 1 | Recovery loop locked |
| sd_in0 | input | 1 | Signal detect, input 0 |
| sd_in1 | input | 1 | Signal detect, input 1 |
| raw_in0 | input | 1 | Raw data stream, input 0 |
| raw_in1 | input | 1 | Raw data stream, input 1 |
| retimed_data | input | 1 | Retimed data stream |
| fullrate_clk | input | 1 | Full-rate recovered clock stream |
| clk297 | input | 1 | 297 MHz clock stream |
| ref10m_clk | input | 1 | 10 MHz reference clock stream |
| div_clk | input | 1 | Divided clock stream |
| out0 | output | 1 | Output 0 serial stream |
| out1 | output | 1 | Output 1 serial stream |
| out0_pd | output | 1 | Output 0 powered down |
| out1_pd | output | 1 | Output 1 powered down |

## Verification
A link state that is wrong shows up one clock after the lock or signal-detect change. It can appear as retimed data where raw data belongs, or as a clock or data on output 1 that should be silent. It can also appear as power-down flags still set after a signal has arrived. The bench toggles each source stream alone while a configuration is held. This shows exactly which source reaches each output, and a wrong selection is caught within the same configuration step. Lock changes are sampled both before and after the clock edge so that the one-clock latency is observed.

// File: rtl/lmsel_pkg.sv
package lmsel_pkg;
    localparam int ROUTE_W = 2;
    localparam int MODE_W  = 2;
    localparam int CODE_W  = 3;

    typedef enum logic [1:0] {
        LINK_DARK    = 2'd0,
        LINK_ACQUIRE = 2'd1,
        LINK_LOCKED  = 2'd2
    } link_state_e;

    typedef enum logic [2:0] {
        SRC_MUTE    = 3'd0,
        SRC_RAW     = 3'd1,
        SRC_RETIMED = 3'd2,
        SRC_FULLCLK = 3'd3,
        SRC_CLK297  = 3'd4,
        SRC_REF10   = 3'd5,
        SRC_DIV     = 3'd6
    } src_e;
endpackage

// File: rtl/lmsel_link_fsm.sv
module lmsel_link_fsm
    import lmsel_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sd_act,
    input  logic        lock,
    output link_state_e state
);
    link_state_e next_state;

    always_comb begin
        next_state = state;
        unique case (state)
            LINK_DARK, LINK_ACQUIRE, LINK_LOCKED: begin
                if (!sd_act)    next_state = LINK_DARK;
                else if (!lock) next_state = LINK_ACQUIRE;
                else            next_state = LINK_LOCKED;
            end
            default: next_state = LINK_DARK;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= LINK_DARK;
        else        state <= next_state;
    end

    // R2: locked state only after signal and lock were both seen
    assert_locked_needs_both_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == LINK_LOCKED) |-> $past(sd_act && lock));
    // R2: a lost signal forces dark on the next clock
    assert_loss_goes_dark_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !sd_act |=> (state == LINK_DARK));
endmodule

// File: rtl/lmsel_out0_sel.sv
module lmsel_out0_sel
    import lmsel_pkg::*;
(
    input  link_state_e         state,
    input  logic [MODE_W-1:0]   glob_mode,
    input  logic                ovr_en,
    input  logic [CODE_W-1:0]   code0,
    input  logic [CODE_W-1:0]   code1,
    input  logic                div_sel,
    output src_e                sel
);
    logic locked;
    logic ten_meg_ok;

    assign locked     = (state == LINK_LOCKED);
    assign ten_meg_ok = (code1 == 3'b101) && !div_sel;

    always_comb begin
        sel = SRC_MUTE;
        if (state != LINK_DARK) begin
            if (!ovr_en) begin
                unique case (glob_mode)
                    2'b00:        sel = SRC_MUTE;
                    2'b01, 2'b10: sel = locked ? SRC_RETIMED : SRC_RAW;
                    default:      sel = SRC_RAW;
                endcase
            end else begin
                unique case (code0)
                    3'b000:  sel = SRC_MUTE;
                    3'b001:  sel = ten_meg_ok ? SRC_REF10 : SRC_MUTE;
                    3'b010:  sel = SRC_RAW;
                    3'b100:  sel = locked ? SRC_RETIMED : SRC_MUTE;
                    default: sel = SRC_MUTE;
                endcase
            end
        end
    end
endmodule

// File: rtl/lmsel_out1_sel.sv
module lmsel_out1_sel
    import lmsel_pkg::*;
(
    input  link_state_e         state,
    input  logic [MODE_W-1:0]   glob_mode,
    input  logic                ovr_en,
    input  logic [CODE_W-1:0]   code1,
    input  logic                div_sel,
    input  logic                rate_high,
    output src_e                sel
);
    logic locked;
    assign locked = (state == LINK_LOCKED);

    always_comb begin
        sel = SRC_MUTE;
        if (state != LINK_DARK) begin
            if (!ovr_en) begin
                unique case (glob_mode)
                    2'b00:   sel = SRC_MUTE;
                    2'b01:   sel = !locked ? SRC_MUTE :
                                   (rate_high ? SRC_CLK297 : SRC_FULLCLK);
                    2'b10:   sel = locked ? SRC_RETIMED : SRC_RAW;
                    default: sel = SRC_RAW;
                endcase
            end else begin
                unique case (code1)
                    3'b111:  sel = SRC_MUTE;
                    3'b101:  sel = div_sel ? SRC_DIV : SRC_REF10;
                    3'b010:  sel = SRC_FULLCLK;
                    3'b001:  sel = locked ? SRC_RETIMED : SRC_MUTE;
                    3'b000:  sel = SRC_RAW;
                    default: sel = SRC_MUTE;
                endcase
            end
        end
    end
endmodule

// File: rtl/lock_aware_out_sel.sv
module lock_aware_out_sel
    import lmsel_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ROUTE_W-1:0] route_sel,
    input  logic [MODE_W-1:0]  glob_mode,
    input  logic               ovr_en,
    input  logic [CODE_W-1:0]  out0_code,
    input  logic [CODE_W-1:0]  out1_code,
    input  logic               div_sel,
    input  logic               out1_inv,
    input  logic               rate_high,
    input  logic               cdr_lock,
    input  logic               sd_in0,
    input  logic               sd_in1,
    input  logic               raw_in0,
    input  logic               raw_in1,
    input  logic               retimed_data,
    input  logic               fullrate_clk,
    input  logic               clk297,
    input  logic               ref10m_clk,
    input  logic               div_clk,
    output logic               out0,
    output logic               out1,
    output logic               out0_pd,
    output logic               out1_pd
);
    link_state_e state;
    src_e        sel0, sel1;
    logic        sd_act, raw_act, dark;

    assign sd_act  = route_sel[1] ? sd_in1  : sd_in0;
    assign raw_act = route_sel[1] ? raw_in1 : raw_in0;

    lmsel_link_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .sd_act(sd_act), .lock(cdr_lock), .state(state)
    );

    lmsel_out0_sel u_sel0 (
        .state(state), .glob_mode(glob_mode), .ovr_en(ovr_en),
        .code0(out0_code), .code1(out1_code), .div_sel(div_sel), .sel(sel0)
    );

    lmsel_out1_sel u_sel1 (
        .state(state), .glob_mode(glob_mode), .ovr_en(ovr_en),
        .code1(out1_code), .div_sel(div_sel), .rate_high(rate_high), .sel(sel1)
    );

    function automatic logic pick(input src_e s, input logic raw_b, input logic ret_b,
                                  input logic fc_b, input logic c297_b,
                                  input logic r10_b, input logic dv_b);
        unique case (s)
            SRC_RAW:     return raw_b;
            SRC_RETIMED: return ret_b;
            SRC_FULLCLK: return fc_b;
            SRC_CLK297:  return c297_b;
            SRC_REF10:   return r10_b;
            SRC_DIV:     return dv_b;
            default:     return 1'b0;
        endcase
    endfunction

    assign dark    = (state == LINK_DARK);
    assign out0_pd = dark || (route_sel == 2'b10);
    assign out1_pd = dark || (route_sel == 2'b01);

    always_comb begin
        out0 = 1'b0;
        out1 = 1'b0;
        if (!out0_pd)
            out0 = pick(sel0, raw_act, retimed_data, fullrate_clk, clk297, ref10m_clk, div_clk);
        if (!out1_pd && sel1 != SRC_MUTE)
            out1 = out1_inv ^ pick(sel1, raw_act, retimed_data, fullrate_clk, clk297,
                                   ref10m_clk, div_clk);
    end

    // R1: route 01 keeps output 1 powered down and silent
    assert_route01_out1_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (route_sel == 2'b01) |-> (out1_pd && !out1));
    // R1: a powered-down output 0 is silent
    assert_pd0_silent_R1: assert property (@(posedge clk) disable iff (!rst_n)
        out0_pd |-> !out0);
    // R3: global mute
    assert_global_mute_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ovr_en && glob_mode == 2'b00) |-> (!out0 && !out1));
    // R8: the 10 MHz clock on output 0 needs signal and output 1 on code 101
    assert_ten_meg_pair_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sel0 == SRC_REF10) |-> (!dark && out1_code == 3'b101 && !div_sel));
    // R9: no retimed data while not locked
    assert_retimed_locked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (sel0 == SRC_RETIMED || sel1 == SRC_RETIMED) |-> $past(cdr_lock));
    // R10: an explicitly muted output 1 stays at 0 whatever the polarity
    assert_mute_ignores_inv_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_en && out1_code == 3'b111) |-> !out1);
endmodule

// File: tb/tb_lock_aware_out_sel.sv
module tb_lock_aware_out_sel;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] route_sel = 2'b00, glob_mode = 2'b00;
    logic ovr_en = 1'b0, div_sel = 1'b0, out1_inv = 1'b0, rate_high = 1'b0;
    logic [2:0] out0_code = 3'b000, out1_code = 3'b000;
    logic cdr_lock = 1'b0, sd_in0 = 1'b0, sd_in1 = 1'b0;
    // source index: 0 raw_in0, 1 raw_in1, 2 retimed, 3 fullrate, 4 clk297, 5 ref10m, 6 div
    logic [6:0] srcs = 7'd0;
    logic out0, out1, out0_pd, out1_pd;
    int checks = 0, errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    lock_aware_out_sel dut (
        .clk(clk), .rst_n(rst_n), .route_sel(route_sel), .glob_mode(glob_mode),
        .ovr_en(ovr_en), .out0_code(out0_code), .out1_code(out1_code),
        .div_sel(div_sel), .out1_inv(out1_inv), .rate_high(rate_high),
        .cdr_lock(cdr_lock), .sd_in0(sd_in0), .sd_in1(sd_in1),
        .raw_in0(srcs[0]), .raw_in1(srcs[1]), .retimed_data(srcs[2]),
        .fullrate_clk(srcs[3]), .clk297(srcs[4]), .ref10m_clk(srcs[5]), .div_clk(srcs[6]),
        .out0(out0), .out1(out1), .out0_pd(out0_pd), .out1_pd(out1_pd)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    // apply settings already driven; let the link state settle
    task automatic settle();
        @(posedge clk);
        @(negedge clk);
    endtask

    // e0/e1: expected source index per output, -1 for silent
    task automatic probe(input string req, input int e0, input int e1);
        for (int k = 0; k < 7; k++) begin
            srcs = 7'd1 << k;
            #1;
            chk(req, out0, (e0 == k));
            chk(req, out1, (e1 < 0) ? 1'b0 : (((e1 == k) ? 1'b1 : 1'b0) ^ out1_inv));
        end
        srcs = 7'd0;
        #1;
    endtask

    task automatic set_link(input logic sd, input logic lk);
        sd_in0 = sd; sd_in1 = sd; cdr_lock = lk;
        settle();
    endtask

    task automatic t_reset();
        chk("R2 reset pd0", out0_pd, 1'b1);
        chk("R2 reset pd1", out1_pd, 1'b1);
        glob_mode = 2'b11;
        probe("R2 reset silent", -1, -1);
    endtask

    task automatic t_route();
        glob_mode = 2'b11; ovr_en = 1'b0;
        set_link(1'b1, 1'b1);
        route_sel = 2'b00; settle();
        chk("R1 r00 pd0", out0_pd, 1'b0); chk("R1 r00 pd1", out1_pd, 1'b0);
        probe("R1 route 00", 0, 0);
        route_sel = 2'b01; settle();
        chk("R1 r01 pd1", out1_pd, 1'b1); chk("R1 r01 pd0", out0_pd, 1'b0);
        probe("R1 route 01", 0, -1);
        route_sel = 2'b10; settle();
        chk("R1 r10 pd0", out0_pd, 1'b1); chk("R1 r10 pd1", out1_pd, 1'b0);
        probe("R1 route 10", -1, 1);
        route_sel = 2'b11; settle();
        probe("R1 route 11", 1, 1);
        // only input 1's detect matters on route 11
        sd_in1 = 1'b0; sd_in0 = 1'b1; settle();
        chk("R1 r11 sd from in1", out0_pd, 1'b1);
        route_sel = 2'b00; settle();
        chk("R1 r00 sd from in0", out0_pd, 1'b0);
    endtask

    task automatic t_latency();
        route_sel = 2'b00; glob_mode = 2'b10; ovr_en = 1'b0;
        set_link(1'b1, 1'b1);
        srcs = 7'b0000100;
        cdr_lock = 1'b0;
        #1 chk("R2 lock drop not yet seen", out0, 1'b1);
        @(posedge clk); #1;
        chk("R2 lock drop seen after edge", out0, 1'b0);
        srcs = 7'b0000001; #1;
        chk("R2 raw after lock drop", out0, 1'b1);
        srcs = 7'd0;
        @(negedge clk);
        sd_in0 = 1'b0;
        #1 chk("R2 sd drop not yet seen", out0_pd, 1'b0);
        @(posedge clk); #1;
        chk("R2 dark after edge pd0", out0_pd, 1'b1);
        chk("R2 dark after edge pd1", out1_pd, 1'b1);
        @(negedge clk);
        cdr_lock = 1'b1; settle();
        probe("R2 dark with lock still silent", -1, -1);
    endtask

    task automatic t_global();
        route_sel = 2'b00; ovr_en = 1'b0;
        set_link(1'b1, 1'b1);
        glob_mode = 2'b00; #1; probe("R3 mode 00", -1, -1);
        glob_mode = 2'b01; rate_high = 1'b0; #1; probe("R4 mode 01 low rate", 2, 3);
        rate_high = 1'b1; #1; probe("R4 mode 01 high rate", 2, 4);
        set_link(1'b1, 1'b0); probe("R4 mode 01 unlocked", 0, -1);
        glob_mode = 2'b10; #1; probe("R5 mode 10 unlocked", 0, 0);
        glob_mode = 2'b11; #1; probe("R5 mode 11 unlocked", 0, 0);
        set_link(1'b1, 1'b1);
        glob_mode = 2'b10; #1; probe("R5 mode 10 locked", 2, 2);
        glob_mode = 2'b11; #1; probe("R5 mode 11 locked", 0, 0);
        rate_high = 1'b0;
    endtask

    task automatic t_override();
        route_sel = 2'b00; ovr_en = 1'b1; glob_mode = 2'b00; div_sel = 1'b0;
        set_link(1'b1, 1'b1);
        out0_code = 3'b010; out1_code = 3'b000; #1; probe("R6 R7 raw codes", 0, 0);
        out0_code = 3'b100; out1_code = 3'b001; #1; probe("R6 R7 retimed codes", 2, 2);
        out0_code = 3'b000; out1_code = 3'b010; #1; probe("R6 R7 mute / fullrate", -1, 3);
        out1_code = 3'b111; #1; probe("R7 code 111 mute", -1, -1);
        out1_code = 3'b101; div_sel = 1'b1; out0_code = 3'b001; #1;
        probe("R7 R8 divided clock, out0 no 10M", -1, 6);
        div_sel = 1'b0; #1; probe("R8 10M on both", 5, 5);
        set_link(1'b1, 1'b0); probe("R8 10M needs no lock", 5, 5);
        out1_code = 3'b000; #1; probe("R8 out0 10M needs out1 on 101", -1, 0);
        out1_code = 3'b101;
        set_link(1'b0, 1'b0); probe("R8 no 10M without signal", -1, -1);
    endtask

    task automatic t_unlocked_retimed();
        route_sel = 2'b00; ovr_en = 1'b1; div_sel = 1'b0;
        set_link(1'b1, 1'b0);
        out0_code = 3'b100; out1_code = 3'b001; #1;
        probe("R9 retimed while unlocked", -1, -1);
    endtask

    task automatic t_invert();
        route_sel = 2'b00; ovr_en = 1'b0; out1_inv = 1'b1;
        set_link(1'b1, 1'b1);
        glob_mode = 2'b11; #1; probe("R10 inverted raw", 0, 0);
        glob_mode = 2'b00; #1; probe("R10 mute stays 0", -1, -1);
        route_sel = 2'b01; settle(); probe("R10 powered down stays 0", -1, -1);
        route_sel = 2'b00; out1_inv = 1'b0; settle();
    endtask

    task automatic t_invalid();
        route_sel = 2'b00; ovr_en = 1'b1; div_sel = 1'b0;
        set_link(1'b1, 1'b1);
        out1_code = 3'b000;
        for (int c = 3; c < 8; c++) begin
            if (c == 4) continue;
            out0_code = 3'(c); #1;
            probe("R11 invalid out0 code", -1, 0);
        end
        out0_code = 3'b010;
        for (int c = 3; c < 7; c++) begin
            if (c == 5) continue;
            out1_code = 3'(c); #1;
            probe("R11 invalid out1 code", 0, -1);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_route();
        t_latency();
        t_global();
        t_override();
        t_unlocked_retimed();
        t_invert();
        t_invalid();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule